// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block turns message-signalled interrupts into a single level interrupt for a host processor. Every inbound write seen by the snoop port is compared against a programmable 64-bit doorbell address. When a full-word write hits that doorbell while the bank is open, the low bits of the written data select one of the interrupt vectors, and the matching pending bit is recorded if that vector is enabled.

Software sets up the doorbell address, the per-vector enable and mask words, and services interrupts through a small register port indexed by word. Enable and mask act at two different points. Enable decides whether a vector is recorded at all. Mask only keeps a recorded vector from raising the interrupt line. Pending bits are cleared by toggling them. The line is released only when a status write leaves no bit pending. Inbound reads at the doorbell are never taken by the block and continue as ordinary reads.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset the doorbell address halves, the enable, mask and status words all read 0, and `irq` is low.
- R2: A register write to index 0 replaces only bits 31:0 of the doorbell address, and a write to index 1 replaces only bits 63:32. The other half keeps its value.
- R3: `snp_claim` is high in the same cycle as a snoop beat only if the beat is valid, is a write, has all four byte enables set, has an address equal to the full doorbell address, and the enable word is nonzero.
- R4: A claimed write with data v sets status bit v[4:0] if enable bit v[4:0] is 1. Data bits 31:5 are ignored. If that enable bit is 0, the status word does not change.
- R5: On the clock edge that accepts a claimed write, `irq` goes high if at least one status bit is set whose mask bit is 0. A change to the mask word alone never raises `irq`.
- R6: A register write to index 4 (status) inverts every status bit whose written data bit is 1 and leaves the others unchanged.
- R7: `irq` goes low only on a status write that leaves the whole status word at 0. Setting mask bits does not lower it.
- R8: A snoop read at the doorbell address is not claimed and does not change the status word or `irq`.
- R9: When a claimed write and a status write happen in the same cycle, the vector bit is set first and the toggle is then applied to the result.
- R10: The register read port is combinational: index 0 and 1 return the address halves, 2 the enable word, 3 the mask word, 4 the status word, and indices 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register word index for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_idx` |
| snp_valid | input | 1 | Inbound beat valid |
| snp_write | input | 1 | 1 = inbound write, 0 = inbound read |
| snp_addr | input | 64 | Inbound byte address |
| snp_be | input | 4 | Inbound byte enables |
| snp_data | input | 32 | Inbound write data |
| snp_claim | output | 1 | Beat is taken by the doorbell (same cycle) |
| irq | output | 1 | Level interrupt to the host |

## Verification
`snp_claim` and `cfg_rdata` are combinational, so they are due in the cycle in which the stimulus is driven. Register contents, pending bits and `irq` change on the edge that accepts the write, so they are due one cycle later. The bench drives one time step after a rising edge. It queues each expected value at the point where it becomes due, and the monitor compares it on the following falling edge. This means every registered result is sampled on the first falling edge after the edge that produced it.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

    localparam int unsigned CFG_IDX_W = 3;

    typedef enum logic [CFG_IDX_W-1:0] {
        RIDX_BASE_LO = 3'd0,
        RIDX_BASE_HI = 3'd1,
        RIDX_ENABLE  = 3'd2,
        RIDX_MASK    = 3'd3,
        RIDX_STATUS  = 3'd4
    } cfg_idx_e;

    typedef struct packed {
        logic valid;
        logic is_write;
        logic full_word;
    } snp_ctl_t;

    typedef struct packed {
        logic            wr;
        cfg_idx_e        idx;
    } cfg_cmd_t;

    function automatic logic is_status_write(input cfg_cmd_t cmd);
        return cmd.wr && (cmd.idx == RIDX_STATUS);
    endfunction

endpackage

// File: rtl/msi_cap_regfile.sv
module msi_cap_regfile
    import msi_cap_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NVEC   = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  cfg_cmd_t              cmd_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [NVEC-1:0]       status_i,
    output logic [2*DATA_W-1:0]   base_o,
    output logic [NVEC-1:0]       enable_o,
    output logic [NVEC-1:0]       mask_o,
    output logic [DATA_W-1:0]     rdata_o
);
    localparam int unsigned ADDR_W = 2 * DATA_W;

    logic [ADDR_W-1:0] base_q;
    logic [NVEC-1:0]   enable_q;
    logic [NVEC-1:0]   mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            enable_q <= '0;
            mask_q   <= '0;
        end else if (cmd_i.wr) begin
            case (cmd_i.idx)
                RIDX_BASE_LO: base_q[DATA_W-1:0]      <= wdata_i;
                RIDX_BASE_HI: base_q[ADDR_W-1:DATA_W] <= wdata_i;
                RIDX_ENABLE:  enable_q                <= wdata_i[NVEC-1:0];
                RIDX_MASK:    mask_q                  <= wdata_i[NVEC-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (cmd_i.idx)
            RIDX_BASE_LO: rdata_o = base_q[DATA_W-1:0];
            RIDX_BASE_HI: rdata_o = base_q[ADDR_W-1:DATA_W];
            RIDX_ENABLE:  rdata_o[NVEC-1:0] = enable_q;
            RIDX_MASK:    rdata_o[NVEC-1:0] = mask_q;
            RIDX_STATUS:  rdata_o[NVEC-1:0] = status_i;
            default:      rdata_o = '0;
        endcase
    end

    assign base_o   = base_q;
    assign enable_o = enable_q;
    assign mask_o   = mask_q;

    // R2: a low-half write keeps the high half
    assert_base_lo_only_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.wr && cmd_i.idx == RIDX_BASE_LO) |=> $stable(base_q[ADDR_W-1:DATA_W]));

    // R2: a high-half write keeps the low half
    assert_base_hi_only_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.wr && cmd_i.idx == RIDX_BASE_HI) |=> $stable(base_q[DATA_W-1:0]));

endmodule

// File: rtl/msi_cap_match.sv
module msi_cap_match
    import msi_cap_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NVEC   = 32
) (
    input  snp_ctl_t              ctl_i,
    input  logic [2*DATA_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]     data_i,
    input  logic [2*DATA_W-1:0]   base_i,
    input  logic [NVEC-1:0]       enable_i,
    output logic                  claim_o,
    output logic [NVEC-1:0]       set_vec_o
);
    localparam int unsigned VIX_W = (NVEC > 1) ? $clog2(NVEC) : 1;

    logic              window_open;
    logic              addr_hit;
    logic [VIX_W-1:0]  vec_idx;
    logic [NVEC-1:0]   vec_dec;

    assign window_open = |enable_i;
    assign addr_hit    = (addr_i == base_i);
    assign vec_idx     = data_i[VIX_W-1:0];

    assign claim_o = ctl_i.valid && ctl_i.is_write && ctl_i.full_word
                     && addr_hit && window_open;

    for (genvar g = 0; g < NVEC; g++) begin : g_dec
        assign vec_dec[g] = (vec_idx == VIX_W'(g));
    end

    assign set_vec_o = claim_o ? (vec_dec & enable_i) : '0;

    // R4: at most one vector is recorded per beat
    always_comb begin
        assert_one_vector_R4: assert ($onehot0(set_vec_o));
    end

endmodule

// File: rtl/msi_cap_bank.sv
module msi_cap_bank
    import msi_cap_pkg::*;
#(
    parameter int unsigned NVEC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              claim_i,
    input  logic [NVEC-1:0]   set_vec_i,
    input  logic              stat_wr_i,
    input  logic [NVEC-1:0]   tgl_i,
    input  logic [NVEC-1:0]   mask_i,
    input  logic [NVEC-1:0]   enable_i,
    output logic [NVEC-1:0]   status_o,
    output logic              irq_o
);
    logic [NVEC-1:0] status_q;
    logic [NVEC-1:0] after_set;
    logic [NVEC-1:0] status_d;
    logic            unmasked_pend;
    logic            irq_q;
    logic            irq_d;

    always_comb begin
        after_set     = status_q | set_vec_i;
        status_d      = stat_wr_i ? (after_set ^ tgl_i) : after_set;
        unmasked_pend = |(status_d & ~mask_i);
        irq_d         = irq_q;
        if (claim_i && unmasked_pend)
            irq_d = 1'b1;
        if (stat_wr_i && (status_d == '0))
            irq_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            irq_q    <= irq_d;
        end
    end

    assign status_o = status_q;
    assign irq_o    = irq_q;

    // R7: the line drops only after a status write that empties the bank
    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_q) |-> ($past(stat_wr_i) && status_q == '0));

    // R5: the line rises only after a claimed write
    assert_irq_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(claim_i));

    // R4: without a status write, new pending bits appear only on enabled vectors
    assert_enabled_only_R4: assert property (@(posedge clk) disable iff (rst)
        !stat_wr_i |=> ((status_q & ~$past(status_q) & ~$past(enable_i)) == '0));

    // R8: no claim and no status write leaves the bank untouched
    assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!claim_i && !stat_wr_i) |=> $stable(status_q));

    // R9: merged set then toggle
    assert_merge_order_R9: assert property (@(posedge clk) disable iff (rst)
        (claim_i && stat_wr_i) |=>
            (status_q == (($past(status_q) | $past(set_vec_i)) ^ $past(tgl_i))));

endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
    import msi_cap_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NVEC   = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  logic [2:0]            cfg_idx,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output logic [DATA_W-1:0]     cfg_rdata,
    input  logic                  snp_valid,
    input  logic                  snp_write,
    input  logic [2*DATA_W-1:0]   snp_addr,
    input  logic [DATA_W/8-1:0]   snp_be,
    input  logic [DATA_W-1:0]     snp_data,
    output logic                  snp_claim,
    output logic                  irq
);
    localparam int unsigned ADDR_W = 2 * DATA_W;

    cfg_cmd_t          cmd;
    snp_ctl_t          sctl;
    logic [ADDR_W-1:0] base;
    logic [NVEC-1:0]   enable;
    logic [NVEC-1:0]   mask;
    logic [NVEC-1:0]   status;
    logic [NVEC-1:0]   set_vec;
    logic              claim;
    logic              stat_wr;

    assign cmd.wr  = cfg_wr;
    assign cmd.idx = cfg_idx_e'(cfg_idx);

    assign sctl.valid     = snp_valid;
    assign sctl.is_write  = snp_write;
    assign sctl.full_word = &snp_be;

    assign stat_wr = is_status_write(cmd);

    msi_cap_regfile #(.DATA_W(DATA_W), .NVEC(NVEC)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd),
        .wdata_i  (cfg_wdata),
        .status_i (status),
        .base_o   (base),
        .enable_o (enable),
        .mask_o   (mask),
        .rdata_o  (cfg_rdata)
    );

    msi_cap_match #(.DATA_W(DATA_W), .NVEC(NVEC)) u_match (
        .ctl_i     (sctl),
        .addr_i    (snp_addr),
        .data_i    (snp_data),
        .base_i    (base),
        .enable_i  (enable),
        .claim_o   (claim),
        .set_vec_o (set_vec)
    );

    msi_cap_bank #(.NVEC(NVEC)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .claim_i   (claim),
        .set_vec_i (set_vec),
        .stat_wr_i (stat_wr),
        .tgl_i     (cfg_wdata[NVEC-1:0]),
        .mask_i    (mask),
        .enable_i  (enable),
        .status_o  (status),
        .irq_o     (irq)
    );

    assign snp_claim = claim;

    // R8: inbound reads are never taken
    assert_read_passes_R8: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && !snp_write) |-> !snp_claim);

endmodule

// File: tb/sim_msi_capture_ctrl.sv
module sim_msi_capture_ctrl;

    localparam int K_RD    = 0;
    localparam int K_IRQ   = 1;
    localparam int K_CLAIM = 2;

    typedef struct {
        string       req;
        int          kind;
        logic [31:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        snp_valid = 1'b0;
    logic        snp_write = 1'b0;
    logic [63:0] snp_addr = '0;
    logic [3:0]  snp_be = '0;
    logic [31:0] snp_data = '0;
    logic        snp_claim;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    item_t sb_q[$];

    localparam logic [63:0] BASE = 64'h0000_ABCD_1000_0080;

    always #10 clk = ~clk;

    msi_capture_ctrl u0 (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .snp_be(snp_be), .snp_data(snp_data), .snp_claim(snp_claim), .irq(irq)
    );

    // monitor: compare queued expectations on the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_RD:    act = cfg_rdata;
                K_IRQ:   act = {31'd0, irq};
                default: act = {31'd0, snp_claim};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(input string req, input int kind, input logic [31:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic reg_write(input logic [2:0] idx, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic check_reg(input logic [2:0] idx, input logic [31:0] exp, input string req);
        @(posedge clk); #1;
        cfg_idx = idx;
        push(req, K_RD, exp);
    endtask

    task automatic check_irq(input logic exp, input string req);
        @(posedge clk); #1;
        push(req, K_IRQ, {31'd0, exp});
    endtask

    task automatic beat(input logic wr, input logic [63:0] a, input logic [3:0] be,
                        input logic [31:0] d, input logic exp_claim, input string req);
        @(posedge clk); #1;
        snp_valid = 1'b1; snp_write = wr; snp_addr = a; snp_be = be; snp_data = d;
        push(req, K_CLAIM, {31'd0, exp_claim});
        @(posedge clk); #1;
        snp_valid = 1'b0;
    endtask

    task automatic merged(input logic [31:0] vec_data, input logic [31:0] tgl);
        @(posedge clk); #1;
        snp_valid = 1'b1; snp_write = 1'b1; snp_addr = BASE; snp_be = 4'hF; snp_data = vec_data;
        cfg_wr = 1'b1; cfg_idx = 3'd4; cfg_wdata = tgl;
        push("R9", K_CLAIM, 32'd1);
        @(posedge clk); #1;
        snp_valid = 1'b0; cfg_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 5; i++) check_reg(3'(i), 32'd0, "R1");
        check_irq(1'b0, "R1");

        // R2 address halves
        reg_write(3'd0, 32'h1000_0040);
        check_reg(3'd0, 32'h1000_0040, "R2");
        check_reg(3'd1, 32'h0, "R2");
        reg_write(3'd1, 32'h0000_ABCD);
        check_reg(3'd0, 32'h1000_0040, "R2");
        reg_write(3'd0, 32'h1000_0080);
        check_reg(3'd1, 32'h0000_ABCD, "R2");
        check_reg(3'd0, 32'h1000_0080, "R10");

        // R3 window closed while enable is zero
        beat(1'b1, BASE, 4'hF, 32'd2, 1'b0, "R3");
        check_reg(3'd4, 32'h0, "R3");

        reg_write(3'd2, 32'h0000_00F5);
        check_reg(3'd2, 32'h0000_00F5, "R10");
        check_reg(3'd3, 32'h0, "R10");

        // R4/R5 capture
        beat(1'b1, BASE, 4'hF, 32'd2, 1'b1, "R3");
        check_reg(3'd4, 32'h0000_0004, "R4");
        check_irq(1'b1, "R5");
        beat(1'b1, BASE, 4'hF, 32'd1, 1'b1, "R4");
        check_reg(3'd4, 32'h0000_0004, "R4");
        beat(1'b1, BASE, 4'hF, 32'hFFFF_FF25, 1'b1, "R4");
        check_reg(3'd4, 32'h0000_0024, "R4");

        // R3 misses
        beat(1'b1, BASE + 64'd4, 4'hF, 32'd0, 1'b0, "R3");
        beat(1'b1, BASE, 4'h3, 32'd0, 1'b0, "R3");
        beat(1'b1, BASE ^ 64'h0000_0001_0000_0000, 4'hF, 32'd0, 1'b0, "R3");
        check_reg(3'd4, 32'h0000_0024, "R3");

        // R8 read passes
        beat(1'b0, BASE, 4'hF, 32'd7, 1'b0, "R8");
        check_reg(3'd4, 32'h0000_0024, "R8");
        check_irq(1'b1, "R8");

        // R7 mask does not drop irq; R6 toggle
        reg_write(3'd3, 32'hFFFF_FFFF);
        check_irq(1'b1, "R7");
        reg_write(3'd4, 32'h0000_0004);
        check_reg(3'd4, 32'h0000_0020, "R6");
        check_irq(1'b1, "R7");
        reg_write(3'd4, 32'h0000_0020);
        check_reg(3'd4, 32'h0, "R6");
        check_irq(1'b0, "R7");

        // R5 masked capture, mask change alone
        beat(1'b1, BASE, 4'hF, 32'd7, 1'b1, "R5");
        check_reg(3'd4, 32'h0000_0080, "R4");
        check_irq(1'b0, "R5");
        reg_write(3'd3, 32'h0);
        check_irq(1'b0, "R5");
        beat(1'b1, BASE, 4'hF, 32'd0, 1'b1, "R5");
        check_reg(3'd4, 32'h0000_0081, "R4");
        check_irq(1'b1, "R5");

        // R6 toggle can set a bit
        reg_write(3'd4, 32'h0000_0100);
        check_reg(3'd4, 32'h0000_0181, "R6");
        check_irq(1'b1, "R6");

        // R9 merged: set then toggle
        merged(32'd4, 32'h0000_0191);
        check_reg(3'd4, 32'h0, "R9");
        check_irq(1'b0, "R9");
        merged(32'd6, 32'h0000_0001);
        check_reg(3'd4, 32'h0000_0041, "R9");
        check_irq(1'b1, "R9");

        // R10 unmapped indices
        check_reg(3'd5, 32'h0, "R10");
        check_reg(3'd7, 32'h0, "R10");

        @(posedge clk); @(posedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule